// File: doc/BRIEF.md
# Causal Row Softmax Engine

The engine turns a square matrix of attention scores, held in a shared single-port RAM, into a matrix of attention probabilities written back into the same RAM. It handles one row at a time. Row `i` is normalised only over its first `i+1` columns, so every position attends to itself and to earlier positions. All columns to the right of the diagonal are written as exact zeros. Values are signed Q16.16 fixed point.

For each row, one pass reads the visible scores into a small local buffer and tracks their maximum. A second pass turns each buffered score into an exponential of its distance below that maximum, taken from a computed lookup table, and adds the terms up. One cycle then looks up the reciprocal of the sum. A final pass writes the complete row, every visible term scaled by that reciprocal. The exponential table deliberately returns 64520 (about 0.9845) for a zero distance, and this value is used as it stands.

A client places the two base addresses on the inputs and pulses `start`. The engine drives the RAM until the last row is written and then pulses `done`.

Top module: `causal_softmax`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done`, `mem_re` and `mem_we` are all 0.
- R2: A `start` seen while idle captures `score_base` and `prob_base` and raises `busy`. `busy` stays high until the cycle after `done`, when it drops to 0.
- R3: For row `i`, the only words read are `score_base + i*T + j` with `j <= i`. Values stored in masked positions have no effect on any output.
- R4: Every column `j > i` of row `i` is written as exactly 0.
- R5: Let `d = max - s`, where `max` is the largest visible score in the row. The exponential term for `s` is chosen by `k = d >> 14`. For `k = 0` the term is 64520. For `1 <= k <= 31`, the term is `v_k`, where `v_0 = 65536` and `v_k = (v_{k-1} * 51040) >> 16`. For `k >= 32` the term is 0. `d` is formed without overflow over the full signed 32-bit range.
- R6: The row sum `S` of the visible terms sets the reciprocal `r = floor(2^32 / ((S >> 12)*4096 + 2048))`.
- R7: A visible output equals `(term * r) >> 16`.
- R8: Writes go row by row from row 0, and within a row through columns 0 to T-1, to `prob_base + i*T + j`. Each write is a single-cycle `mem_we` pulse. There are no other writes.
- R9: `done` is high for exactly one cycle, the cycle after the final write.
- R10: While busy and not in the `done` cycle, `start` and changes on the base inputs have no effect.
- R11: A `start` in the `done` cycle launches a new run at once, with the newly presented bases.
- R12: `mem_re` and `mem_we` are never high in the same cycle. Read data arrives the cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (accepted when idle or in the done cycle) |
| score_base | input | AW | RAM word address of score row 0, column 0 |
| prob_base | input | AW | RAM word address of probability row 0, column 0 |
| busy | output | 1 | Run in progress, including the done cycle |
| done | output | 1 | One-cycle pulse after the last write |
| mem_re | output | 1 | RAM read strobe |
| mem_we | output | 1 | RAM write strobe |
| mem_addr | output | AW | RAM word address |
| mem_wdata | output | W | RAM write data |
| mem_rdata | input | W | RAM read data, valid the cycle after `mem_re` |

## Verification
The end-of-run `done` pulse and the acceptance of a new `start` can fall in the same cycle. The bench provokes this by holding `start` high, with fresh base addresses, in exactly the cycle where it observes `done`. It judges the result by requiring `busy` to stay high and the second run's 256 writes to follow, each matched against a reference queue built from the new bases. A second `start` with different bases is also sent in the middle of that run. It must leave the address and data stream unchanged.

// File: rtl/causal_softmax.sv
module causal_softmax #(
  parameter int T         = 16,
  parameter int AW        = 12,
  parameter int W         = 32,
  parameter int FRAC      = 16,
  parameter int EXP_N     = 32,
  parameter int EXP_SH    = 14,
  parameter int EXP_ZERO  = 64520,
  parameter int EXP_RATIO = 51040,
  parameter int RCP_SH    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] score_base,
  input  logic [AW-1:0] prob_base,
  output logic          busy,
  output logic          done,
  output logic          mem_re,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic [W-1:0]  mem_rdata
);

  localparam int RW    = $clog2(T);
  localparam int CW    = RW + 1;
  localparam int EIW   = $clog2(EXP_N);
  localparam int RCP_N = ((T << FRAC) >> RCP_SH) + 1;
  localparam int RIW   = $clog2(RCP_N);

  typedef enum logic [2:0] {S_IDLE, S_MAX, S_EXP, S_RCP, S_WR, S_FIN} state_t;

  function automatic logic [W-1:0] exp_entry(input int k);
    logic [2*W-1:0] v;
    v = (2*W)'(1) << FRAC;
    if (k == 0) return W'(EXP_ZERO);
    for (int n = 1; n <= k; n++) v = (v * (2*W)'(EXP_RATIO)) >> FRAC;
    return v[W-1:0];
  endfunction

  function automatic logic [W-1:0] rcp_entry(input int i);
    logic [2*W-1:0] num, den;
    num = (2*W)'(1) << (2*FRAC);
    den = ((2*W)'(i) << RCP_SH) + ((2*W)'(1) << (RCP_SH-1));
    return W'(num / den);
  endfunction

  logic [W-1:0] exp_tab [EXP_N];
  logic [W-1:0] rcp_tab [RCP_N];

  for (genvar k = 0; k < EXP_N; k++) begin : g_exp
    assign exp_tab[k] = exp_entry(k);
  end
  for (genvar k = 0; k < RCP_N; k++) begin : g_rcp
    assign rcp_tab[k] = rcp_entry(k);
  end

  state_t        state;
  logic [RW-1:0] row;
  logic [CW-1:0] cnt, rowx;
  logic [AW-1:0] sbase_q, pbase_q, off;
  logic [W-1:0]  maxv, sum, rcp, ev, rv, cur;
  logic [W-1:0]  sbuf [T];
  logic signed [W:0] diff;
  logic [W:0]    eidx;
  logic [W-1:0]  ridx;

  assign rowx = CW'(row);
  assign cur  = sbuf[cnt[RW-1:0]];
  assign diff = $signed({maxv[W-1], maxv}) - $signed({cur[W-1], cur});
  assign eidx = (W+1)'(diff >>> EXP_SH);
  assign ev   = (eidx < (W+1)'(EXP_N)) ? exp_tab[eidx[EIW-1:0]] : '0;
  assign ridx = sum >> RCP_SH;
  assign rv   = (ridx < W'(RCP_N)) ? rcp_tab[ridx[RIW-1:0]] : '0;

  assign busy      = state != S_IDLE;
  assign done      = state == S_FIN;
  assign mem_re    = (state == S_MAX) && (cnt <= rowx);
  assign mem_we    = state == S_WR;
  assign off       = AW'(int'(row) * T + int'(cnt));
  assign mem_addr  = (mem_we ? pbase_q : sbase_q) + off;
  assign mem_wdata = (mem_we && cnt <= rowx)
                     ? W'(((2*W)'(cur) * (2*W)'(rcp)) >> FRAC) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      row     <= '0;
      cnt     <= '0;
      maxv    <= '0;
      sum     <= '0;
      rcp     <= '0;
      sbase_q <= '0;
      pbase_q <= '0;
    end else begin
      case (state)
        S_IDLE, S_FIN: begin
          if (start) begin
            sbase_q <= score_base;
            pbase_q <= prob_base;
            row     <= '0;
            cnt     <= '0;
            state   <= S_MAX;
          end else begin
            state <= S_IDLE;
          end
        end
        S_MAX: begin
          if (cnt != '0 && (cnt == CW'(1) || $signed(mem_rdata) > $signed(maxv)))
            maxv <= mem_rdata;
          if (cnt == rowx + CW'(1)) begin
            cnt   <= '0;
            state <= S_EXP;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        S_EXP: begin
          sum <= (cnt == '0) ? ev : sum + ev;
          if (cnt == rowx) begin
            cnt   <= '0;
            state <= S_RCP;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        S_RCP: begin
          rcp   <= rv;
          state <= S_WR;
        end
        S_WR: begin
          if (cnt == CW'(T-1)) begin
            cnt <= '0;
            if (row == RW'(T-1)) begin
              state <= S_FIN;
            end else begin
              row   <= row + RW'(1);
              state <= S_MAX;
            end
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_MAX && cnt != '0) sbuf[RW'(cnt - CW'(1))] <= mem_rdata;
    else if (state == S_EXP)         sbuf[cnt[RW-1:0]]      <= ev;
  end

  p_rw_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  p_done_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_we));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  p_max_dominates_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EXP) |-> ($signed(maxv) >= $signed(cur)));

  p_sum_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RCP) |-> (sum >= W'(EXP_ZERO)));

endmodule

// File: tb/causal_softmax_bench.sv
`timescale 1ns/1ps
module causal_softmax_bench;
  localparam int T  = 16;
  localparam int AW = 12;
  localparam int W  = 32;

  logic          clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] score_base = '0, prob_base = '0;
  logic          busy, done, mem_re, mem_we;
  logic [AW-1:0] mem_addr;
  logic [W-1:0]  mem_wdata, mem_rdata;

  logic [31:0] ram [0:(1<<AW)-1];
  int checks = 0, fails = 0, cycles = 0, wr_count = 0;
  int run_sb = 0, run_pb = 0;
  bit pending_done = 0, finished = 0;
  bit [31:0] seed = 32'h1234_5678;
  int q_addr[$];
  longint q_data[$];
  bit q_mask[$];

  always #2 clk = ~clk;

  causal_softmax u_causal_softmax (
    .clk(clk), .rst_n(rst_n), .start(start),
    .score_base(score_base), .prob_base(prob_base),
    .busy(busy), .done(done), .mem_re(mem_re), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    mem_rdata <= ram[mem_addr];
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lcg();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return int'(seed >> 1);
  endfunction

  function automatic longint bexp(input longint d);
    longint k, v;
    k = d >>> 14;
    if (k >= 32) return 0;
    if (k == 0) return 64520;
    v = 65536;
    for (longint n = 1; n <= k; n++) v = (v * 51040) >>> 16;
    return v;
  endfunction

  task automatic model_run(input int sb, input int pb);
    longint e [T];
    longint mx, s, sum, r;
    for (int i = 0; i < T; i++) begin
      mx = longint'(int'(ram[sb + i*T]));
      for (int j = 1; j <= i; j++) begin
        s = longint'(int'(ram[sb + i*T + j]));
        if (s > mx) mx = s;
      end
      sum = 0;
      for (int j = 0; j <= i; j++) begin
        e[j] = bexp(mx - longint'(int'(ram[sb + i*T + j])));
        sum += e[j];
      end
      r = (longint'(1) << 32) / ((sum >>> 12) * 4096 + 2048);
      for (int j = 0; j < T; j++) begin
        q_addr.push_back((pb + i*T + j) % (1 << AW));
        q_data.push_back(j <= i ? (((e[j] * r) >>> 16) & 64'hFFFF_FFFF) : 0);
        q_mask.push_back(j > i);
      end
    end
  endtask

  always @(negedge clk) begin
    bit exp_done;
    int off;
    if (rst_n && !finished) begin
      exp_done = pending_done;
      pending_done = 0;
      if (mem_re) begin
        check(!mem_we, "R12 read and write together", mem_we, 0);
        off = (int'(mem_addr) - run_sb + (1 << AW)) % (1 << AW);
        check((off % T) <= (off / T), "R3 read column beyond diagonal", off % T, off / T);
      end
      if (mem_we) begin
        if (q_addr.size() == 0) begin
          check(0, "R8 unexpected write", mem_addr, -1);
        end else begin
          check(mem_addr == AW'(q_addr[0]), "R8 write address", mem_addr, q_addr[0]);
          if (q_mask[0])
            check(longint'(mem_wdata) == q_data[0], "R4 masked column", mem_wdata, q_data[0]);
          else
            check(longint'(mem_wdata) == q_data[0], "R7 probability (R5, R6 tables)", mem_wdata, q_data[0]);
          if (int'(mem_addr) == run_pb)
            check(mem_wdata == 32'd66601, "R5 lone diagonal term uses 64520", mem_wdata, 66601);
          void'(q_addr.pop_front());
          void'(q_data.pop_front());
          void'(q_mask.pop_front());
        end
        wr_count++;
        if (wr_count % (T*T) == 0) pending_done = 1;
      end
      if (done || exp_done) check(done == exp_done, "R9 done pulse", done, exp_done);
    end
  end

  task automatic go(input int sb, input int pb);
    start = 1;
    score_base = AW'(sb);
    prob_base = AW'(pb);
    run_sb = sb;
    run_pb = pb;
    model_run(sb, pb);
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic fill_a(input int sb);
    for (int i = 0; i < T; i++)
      for (int j = 0; j < T; j++)
        ram[sb + i*T + j] = (j <= i) ? 32'((lcg() % 524288) - 262144) : 32'h7FFF0000;
  endtask

  task automatic fill_b(input int sb);
    for (int i = 0; i < T; i++)
      for (int j = 0; j < T; j++) begin
        logic [31:0] v;
        case (i % 4)
          0: v = 32'h0001_8000;
          1: v = (j == 0) ? 32'd327680 : (j == 1) ? 32'(327680 - 524288) :
                 (j == 2) ? 32'(327680 - 524287) : 32'(-1310720);
          2: v = j[0] ? 32'h8000_0000 : 32'h7FFF_FFFF;
          default: v = 32'((lcg() % 4194304) - 2097152);
        endcase
        ram[sb + i*T + j] = (j <= i) ? v : 32'h8000_0001;
      end
  endtask

  task automatic fill_c(input int sb);
    for (int i = 0; i < T; i++)
      for (int j = 0; j < T; j++)
        ram[sb + i*T + j] = (j <= i) ? 32'((lcg() % 131072) - 65536) : 32'h7FFF_FFFF;
  endtask

  initial begin
    for (int a = 0; a < (1 << AW); a++) ram[a] = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_re && !mem_we, "R1 state during reset", {busy, done, mem_re, mem_we}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !done && !mem_re && !mem_we, "R1 state after reset", {busy, done, mem_re, mem_we}, 0);

    fill_a(0);
    go(0, 256);
    check(busy, "R2 busy after start", busy, 1);
    wait_done();
    @(negedge clk);
    check(!busy, "R2 idle after done", busy, 0);
    check(q_addr.size() == 0, "R8 all writes of run A", q_addr.size(), 0);

    fill_b(512);
    fill_c(1024);
    go(512, 768);
    wait_done();
    go(1024, 1280);
    check(busy, "R11 start in done cycle accepted", busy, 1);
    repeat (100) @(negedge clk);
    start = 1;
    score_base = AW'(0);
    prob_base = AW'(2048);
    @(negedge clk);
    start = 0;
    score_base = AW'(3000);
    check(busy, "R10 start while busy ignored", busy, 1);
    wait_done();
    @(negedge clk);
    check(!busy, "R2 idle after back-to-back run", busy, 0);
    check(q_addr.size() == 0, "R10 no extra run from ignored start", q_addr.size(), 0);
    repeat (5) @(negedge clk);
    check(!mem_we && !done, "R10 quiet after final run", {mem_we, done}, 0);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !finished) begin
        finished = 1;
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end
endmodule